// File: doc/BRIEF.md
# Programmable Interlaced Raster Timing Generator

This block produces the raster timing for a video transmitter. One pixel counter and one line counter run freely on the pixel clock. Every output is a begin/end window on one of them: a horizontal active window, a horizontal sync window, and, per field, a vertical active window and a vertical sync window. The generator runs progressive frames, or interlaced frames made of two fields. In interlaced frames the second field has its own vertical windows, and its vertical sync edges sit at a programmable pixel position partway along the line rather than at line start.

A small state machine sequences the generator. IDLE holds the counters at zero. PROG runs a progressive frame. TOP runs the first interlaced field and BOT runs the second. The transitions are:

- IDLE→PROG or IDLE→TOP when the enable bit is seen high. Interlace mode picks which.
- PROG→PROG, PROG→TOP, BOT→PROG and BOT→TOP at frame end, chosen by the mode in force for the new frame.
- TOP→BOT at the last pixel of the line before vertical active window 0 ends.
- Any state→IDLE when the enable bit is low.

All timing values are held in shadow registers. These load only at a frame boundary, or continuously while the generator is idle.

Top module: `raster_timing_gen`

## Requirements
- R1: While command bit 0 is 0, and during reset, pix_cnt and line_cnt are 0, and de and field are low. hsync equals the captured horizontal polarity bit and vsync equals the captured vertical polarity bit. While idle, polarity changes appear one cycle after they are programmed.
- R2: pix_cnt counts 0 to hact_end-1 and then wraps to 0. line_cnt advances by one at each wrap and returns to 0 after the last line of the frame.
- R3: de is high exactly when pix_cnt is in [hact_beg, hact_end) and line_cnt is in the active window of the current field. Window 0 applies to progressive frames and field 0; window 1 applies to field 1.
- R4: hsync is active while pix_cnt is in [hs_beg, hs_end). Each polarity bit (cfg_hs_low, cfg_vs_low) selects 0 = active-high and 1 = active-low, independently.
- R5: With command bit 1 = 0 (progressive), a frame has vact0_end lines. vsync is active on lines [vs0_beg, vs0_end), with its edges at pixel 0.
- R6: With command bit 1 = 1 (interlaced), a frame has vact1_end lines. field is 0 on lines below vact0_end and switches to 1 at pixel 0 of line vact0_end, staying 1 to frame end.
- R7: In interlaced frames, field 0 vsync uses window vs0 with its edges at pixel 0. Field 1 vsync asserts at pixel hs_beg+vs_shift of line vs1_beg and deasserts at that pixel of line vs1_end.
- R8: Command bit 0 enables the generator and bit 1 selects interlace. On the cycle after the edge where bit 0 is first seen high, the counters show line 0, pixel 0, and the next cycle shows pixel 1. Clearing bit 0 returns the counters to 0 on the next cycle.
- R9: Timing values, polarity bits and the mode bit are captured only at the edge where the frame wraps to line 0, pixel 0, or while disabled. A mid-frame write takes effect from the next frame.
- R10: The progressive setting can be reproduced with these values: line 858, active 138..858, hsync 16..78 active-low, lines 45..525, vsync 9..15 active-low. It then gives 720 de cycles per active line, a 62-cycle low hsync, and vsync low on lines 9..14.
- R11: The interlaced setting can be reproduced with these values: line 2200, active 280..2200, hsync 88..132, windows 22..562 and 585..1125, vsync 2..7 and 564..569, offset 1100. It then gives 1920 de cycles from line 22, a 44-cycle high hsync, and vsync high on lines 2..6 of field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cmd | input | 2 | Bit 0 enable, bit 1 interlaced mode |
| cfg_hs_low | input | 1 | Horizontal sync polarity (1 = active-low) |
| cfg_vs_low | input | 1 | Vertical sync polarity (1 = active-low) |
| cfg_hact_beg | input | PIX_W | First active pixel |
| cfg_hact_end | input | PIX_W | Line length and active end |
| cfg_hs_beg | input | PIX_W | Horizontal sync begin |
| cfg_hs_end | input | PIX_W | Horizontal sync end |
| cfg_vs_shift | input | PIX_W | Field 1 vsync edge offset from hs_beg |
| cfg_vact0_beg | input | LINE_W | Field 0 / progressive first active line |
| cfg_vact0_end | input | LINE_W | Field 0 active end (progressive frame length) |
| cfg_vact1_beg | input | LINE_W | Field 1 first active line |
| cfg_vact1_end | input | LINE_W | Field 1 active end (interlaced frame length) |
| cfg_vs0_beg | input | LINE_W | Field 0 vsync begin line |
| cfg_vs0_end | input | LINE_W | Field 0 vsync end line |
| cfg_vs1_beg | input | LINE_W | Field 1 vsync begin line |
| cfg_vs1_end | input | LINE_W | Field 1 vsync end line |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| field | output | 1 | 0 = first field or progressive, 1 = second field |
| pix_cnt | output | PIX_W | Current pixel position |
| line_cnt | output | LINE_W | Current line position |

## Verification
A wrong state register shows on the field output and on the choice of vertical windows. A missed TOP→BOT step keeps field low past line vact0_end, and the very next pixel shows it. A counter that wraps at the wrong point misplaces hsync and de on the same line, and misplaces vsync no later than the first line where a frame should have ended. A shadow register that loads mid-frame changes the line length or window edges within one line of the write, not at the next frame. The reference model compares every output on every clock, so each of these errors is caught in the cycle it first reaches a port.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    typedef enum logic [1:0] {
        RTG_IDLE = 2'd0,
        RTG_PROG = 2'd1,
        RTG_TOP  = 2'd2,
        RTG_BOT  = 2'd3
    } rtg_state_t;

    localparam int RTG_FIELDS = 2;
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow #(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11,
    parameter int FIELDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_fmode,
    input  logic              in_hs_low,
    input  logic              in_vs_low,
    input  logic [PIX_W-1:0]  in_hact_beg,
    input  logic [PIX_W-1:0]  in_hact_end,
    input  logic [PIX_W-1:0]  in_hs_beg,
    input  logic [PIX_W-1:0]  in_hs_end,
    input  logic [PIX_W-1:0]  in_vs_shift,
    input  logic [LINE_W-1:0] in_va_beg [FIELDS],
    input  logic [LINE_W-1:0] in_va_end [FIELDS],
    input  logic [LINE_W-1:0] in_vs_beg [FIELDS],
    input  logic [LINE_W-1:0] in_vs_end [FIELDS],
    output logic              sh_fmode,
    output logic              sh_hs_low,
    output logic              sh_vs_low,
    output logic [PIX_W-1:0]  sh_hact_beg,
    output logic [PIX_W-1:0]  sh_hact_end,
    output logic [PIX_W-1:0]  sh_hs_beg,
    output logic [PIX_W-1:0]  sh_hs_end,
    output logic [PIX_W-1:0]  sh_vs_shift,
    output logic [LINE_W-1:0] sh_va_beg [FIELDS],
    output logic [LINE_W-1:0] sh_va_end [FIELDS],
    output logic [LINE_W-1:0] sh_vs_beg [FIELDS],
    output logic [LINE_W-1:0] sh_vs_end [FIELDS]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_fmode    <= 1'b0;
            sh_hs_low   <= 1'b0;
            sh_vs_low   <= 1'b0;
            sh_hact_beg <= '0;
            sh_hact_end <= '0;
            sh_hs_beg   <= '0;
            sh_hs_end   <= '0;
            sh_vs_shift <= '0;
        end else if (load) begin
            sh_fmode    <= in_fmode;
            sh_hs_low   <= in_hs_low;
            sh_vs_low   <= in_vs_low;
            sh_hact_beg <= in_hact_beg;
            sh_hact_end <= in_hact_end;
            sh_hs_beg   <= in_hs_beg;
            sh_hs_end   <= in_hs_end;
            sh_vs_shift <= in_vs_shift;
        end
    end

    // one set of vertical windows per field
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_va_beg[f] <= '0;
                sh_va_end[f] <= '0;
                sh_vs_beg[f] <= '0;
                sh_vs_end[f] <= '0;
            end else if (load) begin
                sh_va_beg[f] <= in_va_beg[f];
                sh_va_end[f] <= in_va_end[f];
                sh_vs_beg[f] <= in_vs_beg[f];
                sh_vs_end[f] <= in_vs_end[f];
            end
        end
    end
endmodule

// File: rtl/rtg_sequencer.sv
module rtg_sequencer
    import rtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_en,
    input  logic              cmd_fmode,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] top_end,
    input  logic [LINE_W-1:0] frame_len,
    output rtg_state_t        state,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic              load
);
    rtg_state_t        nxt;
    rtg_state_t        restart;
    logic [PIX_W-1:0]  pix_n;
    logic [LINE_W-1:0] line_n;
    logic              eol;
    logic              eof;
    logic              top_last;

    assign eol      = (pix == line_len - 1'b1);
    assign eof      = eol && (line == frame_len - 1'b1);
    assign top_last = eol && (line == top_end - 1'b1);
    assign restart  = cmd_fmode ? RTG_TOP : RTG_PROG;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RTG_IDLE;
            pix   <= '0;
            line  <= '0;
        end else begin
            state <= nxt;
            pix   <= pix_n;
            line  <= line_n;
        end
    end

    always_comb begin
        nxt    = state;
        pix_n  = pix + 1'b1;
        line_n = line;
        load   = 1'b0;
        if (!cmd_en) begin
            nxt    = RTG_IDLE;
            pix_n  = '0;
            line_n = '0;
            load   = 1'b1;
        end else begin
            unique case (state)
                RTG_IDLE: begin
                    nxt    = restart;
                    pix_n  = '0;
                    line_n = '0;
                    load   = 1'b1;
                end
                RTG_PROG, RTG_BOT: begin
                    if (eof) begin
                        nxt    = restart;
                        pix_n  = '0;
                        line_n = '0;
                        load   = 1'b1;
                    end else if (eol) begin
                        pix_n  = '0;
                        line_n = line + 1'b1;
                    end
                end
                RTG_TOP: begin
                    if (eof) begin
                        nxt    = restart;
                        pix_n  = '0;
                        line_n = '0;
                        load   = 1'b1;
                    end else if (eol) begin
                        pix_n  = '0;
                        line_n = line + 1'b1;
                        if (top_last) nxt = RTG_BOT;
                    end
                end
                default: begin
                    nxt    = RTG_IDLE;
                    pix_n  = '0;
                    line_n = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rtg_raster_out.sv
module rtg_raster_out
    import rtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11,
    parameter int FIELDS = 2
) (
    input  rtg_state_t        state,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic              sh_hs_low,
    input  logic              sh_vs_low,
    input  logic [PIX_W-1:0]  sh_hact_beg,
    input  logic [PIX_W-1:0]  sh_hact_end,
    input  logic [PIX_W-1:0]  sh_hs_beg,
    input  logic [PIX_W-1:0]  sh_hs_end,
    input  logic [PIX_W-1:0]  sh_vs_shift,
    input  logic [LINE_W-1:0] sh_va_beg [FIELDS],
    input  logic [LINE_W-1:0] sh_va_end [FIELDS],
    input  logic [LINE_W-1:0] sh_vs_beg [FIELDS],
    input  logic [LINE_W-1:0] sh_vs_end [FIELDS],
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              field
);
    logic              fsel;
    logic              run;
    logic              h_act;
    logic              h_syn;
    logic              v_act;
    logic              v_syn;
    logic [PIX_W:0]    edge_pix;
    logic [PIX_W:0]    pix_x;
    logic [LINE_W-1:0] vb;
    logic [LINE_W-1:0] ve;

    always_comb begin
        run  = 1'b1;
        fsel = 1'b0;
        unique case (state)
            RTG_IDLE: run  = 1'b0;
            RTG_PROG: fsel = 1'b0;
            RTG_TOP:  fsel = 1'b0;
            RTG_BOT:  fsel = 1'b1;
            default:  run  = 1'b0;
        endcase

        pix_x    = {1'b0, pix};
        // second field moves its vertical sync edges to mid-line
        edge_pix = fsel ? ({1'b0, sh_hs_beg} + {1'b0, sh_vs_shift}) : '0;
        vb       = sh_vs_beg[fsel];
        ve       = sh_vs_end[fsel];

        h_act = (pix >= sh_hact_beg) && (pix < sh_hact_end);
        h_syn = (pix >= sh_hs_beg) && (pix < sh_hs_end);
        v_act = (line >= sh_va_beg[fsel]) && (line < sh_va_end[fsel]);
        v_syn = ((line > vb) || ((line == vb) && (pix_x >= edge_pix))) &&
                ((line < ve) || ((line == ve) && (pix_x < edge_pix)));

        hsync = (run && h_syn) ^ sh_hs_low;
        vsync = (run && v_syn) ^ sh_vs_low;
        de    = run && h_act && v_act;
        field = run && fsel;
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cmd,
    input  logic              cfg_hs_low,
    input  logic              cfg_vs_low,
    input  logic [PIX_W-1:0]  cfg_hact_beg,
    input  logic [PIX_W-1:0]  cfg_hact_end,
    input  logic [PIX_W-1:0]  cfg_hs_beg,
    input  logic [PIX_W-1:0]  cfg_hs_end,
    input  logic [PIX_W-1:0]  cfg_vs_shift,
    input  logic [LINE_W-1:0] cfg_vact0_beg,
    input  logic [LINE_W-1:0] cfg_vact0_end,
    input  logic [LINE_W-1:0] cfg_vact1_beg,
    input  logic [LINE_W-1:0] cfg_vact1_end,
    input  logic [LINE_W-1:0] cfg_vs0_beg,
    input  logic [LINE_W-1:0] cfg_vs0_end,
    input  logic [LINE_W-1:0] cfg_vs1_beg,
    input  logic [LINE_W-1:0] cfg_vs1_end,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              field,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt
);
    localparam int NF = RTG_FIELDS;

    logic [LINE_W-1:0] in_va_beg [NF];
    logic [LINE_W-1:0] in_va_end [NF];
    logic [LINE_W-1:0] in_vs_beg [NF];
    logic [LINE_W-1:0] in_vs_end [NF];
    logic [LINE_W-1:0] sh_va_beg [NF];
    logic [LINE_W-1:0] sh_va_end [NF];
    logic [LINE_W-1:0] sh_vs_beg [NF];
    logic [LINE_W-1:0] sh_vs_end [NF];

    logic              sh_fmode;
    logic              sh_hs_low;
    logic              sh_vs_low;
    logic [PIX_W-1:0]  sh_hact_beg;
    logic [PIX_W-1:0]  sh_hact_end;
    logic [PIX_W-1:0]  sh_hs_beg;
    logic [PIX_W-1:0]  sh_hs_end;
    logic [PIX_W-1:0]  sh_vs_shift;
    logic [LINE_W-1:0] top_end;
    logic [LINE_W-1:0] frame_len;
    logic              load;
    rtg_state_t        state;

    assign in_va_beg[0] = cfg_vact0_beg;
    assign in_va_beg[1] = cfg_vact1_beg;
    assign in_va_end[0] = cfg_vact0_end;
    assign in_va_end[1] = cfg_vact1_end;
    assign in_vs_beg[0] = cfg_vs0_beg;
    assign in_vs_beg[1] = cfg_vs1_beg;
    assign in_vs_end[0] = cfg_vs0_end;
    assign in_vs_end[1] = cfg_vs1_end;

    assign top_end   = sh_va_end[0];
    assign frame_len = sh_fmode ? sh_va_end[1] : sh_va_end[0];

    rtg_shadow #(.PIX_W(PIX_W), .LINE_W(LINE_W), .FIELDS(NF)) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .in_fmode    (cfg_cmd[1]),
        .in_hs_low   (cfg_hs_low),
        .in_vs_low   (cfg_vs_low),
        .in_hact_beg (cfg_hact_beg),
        .in_hact_end (cfg_hact_end),
        .in_hs_beg   (cfg_hs_beg),
        .in_hs_end   (cfg_hs_end),
        .in_vs_shift (cfg_vs_shift),
        .in_va_beg   (in_va_beg),
        .in_va_end   (in_va_end),
        .in_vs_beg   (in_vs_beg),
        .in_vs_end   (in_vs_end),
        .sh_fmode    (sh_fmode),
        .sh_hs_low   (sh_hs_low),
        .sh_vs_low   (sh_vs_low),
        .sh_hact_beg (sh_hact_beg),
        .sh_hact_end (sh_hact_end),
        .sh_hs_beg   (sh_hs_beg),
        .sh_hs_end   (sh_hs_end),
        .sh_vs_shift (sh_vs_shift),
        .sh_va_beg   (sh_va_beg),
        .sh_va_end   (sh_va_end),
        .sh_vs_beg   (sh_vs_beg),
        .sh_vs_end   (sh_vs_end)
    );

    rtg_sequencer #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_en    (cfg_cmd[0]),
        .cmd_fmode (cfg_cmd[1]),
        .line_len  (sh_hact_end),
        .top_end   (top_end),
        .frame_len (frame_len),
        .state     (state),
        .pix       (pix_cnt),
        .line      (line_cnt),
        .load      (load)
    );

    rtg_raster_out #(.PIX_W(PIX_W), .LINE_W(LINE_W), .FIELDS(NF)) u_out (
        .state       (state),
        .pix         (pix_cnt),
        .line        (line_cnt),
        .sh_hs_low   (sh_hs_low),
        .sh_vs_low   (sh_vs_low),
        .sh_hact_beg (sh_hact_beg),
        .sh_hact_end (sh_hact_end),
        .sh_hs_beg   (sh_hs_beg),
        .sh_hs_end   (sh_hs_end),
        .sh_vs_shift (sh_vs_shift),
        .sh_va_beg   (sh_va_beg),
        .sh_va_end   (sh_va_end),
        .sh_vs_beg   (sh_vs_beg),
        .sh_vs_end   (sh_vs_end),
        .hsync       (hsync),
        .vsync       (vsync),
        .de          (de),
        .field       (field)
    );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int LINE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_cmd,
    input rtg_state_t        state,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt,
    input logic              de,
    input logic              hsync,
    input logic              field,
    input logic              sh_fmode,
    input logic              sh_hs_low,
    input logic [PIX_W-1:0]  sh_hact_beg,
    input logic [PIX_W-1:0]  sh_hact_end,
    input logic [PIX_W-1:0]  sh_hs_beg,
    input logic [PIX_W-1:0]  sh_hs_end,
    input logic [PIX_W-1:0]  sh_vs_shift,
    input logic [LINE_W-1:0] top_end
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cmd[0] |=> (pix_cnt == '0 && line_cnt == '0 && !de && !field));

    // R2
    pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RTG_IDLE && cfg_cmd[0] && pix_cnt != sh_hact_end - 1'b1)
        |=> pix_cnt == $past(pix_cnt) + 1'b1);

    // R2
    pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RTG_IDLE && pix_cnt == sh_hact_end - 1'b1) |=> pix_cnt == '0);

    // R3
    de_hwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pix_cnt >= sh_hact_beg && pix_cnt < sh_hact_end));

    // R4
    hsync_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt < sh_hs_beg || pix_cnt >= sh_hs_end) |-> hsync == sh_hs_low);

    // R6
    field_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field |-> sh_fmode);

    // R6
    field_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(field) |-> (line_cnt == top_end && pix_cnt == '0));

    // R8
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RTG_IDLE && cfg_cmd[0])
        |=> (state != RTG_IDLE && pix_cnt == '0 && line_cnt == '0));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt != '0) |-> ($stable(sh_hact_end) && $stable(sh_hs_beg) &&
                             $stable(sh_vs_shift) && $stable(top_end)));
endmodule

bind raster_timing_gen rtg_checker #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_rtg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cmd     (cfg_cmd),
    .state       (state),
    .pix_cnt     (pix_cnt),
    .line_cnt    (line_cnt),
    .de          (de),
    .hsync       (hsync),
    .field       (field),
    .sh_fmode    (sh_fmode),
    .sh_hs_low   (sh_hs_low),
    .sh_hact_beg (sh_hact_beg),
    .sh_hact_end (sh_hact_end),
    .sh_hs_beg   (sh_hs_beg),
    .sh_hs_end   (sh_hs_end),
    .sh_vs_shift (sh_vs_shift),
    .top_end     (top_end)
);

// File: tb/raster_timing_gen_bench.sv
`timescale 1ns/1ps
module raster_timing_gen_bench;
    localparam int PW = 12;
    localparam int LW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic          hsl = 1'b0, vsl = 1'b0;
    logic [PW-1:0] hab = '0, hae = '0, hsb = '0, hse = '0, vsh = '0;
    logic [LW-1:0] v0b = '0, v0e = '0, v1b = '0, v1e = '0;
    logic [LW-1:0] s0b = '0, s0e = '0, s1b = '0, s1e = '0;
    logic          hsync, vsync, de, field;
    logic [PW-1:0] pix_cnt;
    logic [LW-1:0] line_cnt;

    always #4 clk = ~clk;

    raster_timing_gen #(.PIX_W(PW), .LINE_W(LW)) u_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_cmd(cmd), .cfg_hs_low(hsl), .cfg_vs_low(vsl),
        .cfg_hact_beg(hab), .cfg_hact_end(hae), .cfg_hs_beg(hsb), .cfg_hs_end(hse),
        .cfg_vs_shift(vsh), .cfg_vact0_beg(v0b), .cfg_vact0_end(v0e),
        .cfg_vact1_beg(v1b), .cfg_vact1_end(v1e), .cfg_vs0_beg(s0b), .cfg_vs0_end(s0e),
        .cfg_vs1_beg(s1b), .cfg_vs1_end(s1e), .hsync(hsync), .vsync(vsync), .de(de),
        .field(field), .pix_cnt(pix_cnt), .line_cnt(line_cnt)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: run flag, field flag, positions, captured settings
    int m_run = 0, m_bot = 0, m_pix = 0, m_line = 0;
    int s_fm = 0, s_hsl = 0, s_vsl = 0, s_hab = 0, s_hae = 0, s_hsb = 0, s_hse = 0, s_sh = 0;
    int s_vab[2] = '{0, 0};
    int s_vae[2] = '{0, 0};
    int s_vsb[2] = '{0, 0};
    int s_vse[2] = '{0, 0};

    task automatic take_settings();
        s_fm = int'(cmd[1]); s_hsl = int'(hsl); s_vsl = int'(vsl);
        s_hab = int'(hab); s_hae = int'(hae); s_hsb = int'(hsb); s_hse = int'(hse);
        s_sh = int'(vsh);
        s_vab[0] = int'(v0b); s_vae[0] = int'(v0e); s_vab[1] = int'(v1b); s_vae[1] = int'(v1e);
        s_vsb[0] = int'(s0b); s_vse[0] = int'(s0e); s_vsb[1] = int'(s1b); s_vse[1] = int'(s1e);
    endtask

    always @(posedge clk) begin
        int total;
        if (!rst_n) begin
            m_run = 0; m_bot = 0; m_pix = 0; m_line = 0;
            s_fm = 0; s_hsl = 0; s_vsl = 0; s_hab = 0; s_hae = 0; s_hsb = 0; s_hse = 0; s_sh = 0;
            s_vab = '{0, 0}; s_vae = '{0, 0}; s_vsb = '{0, 0}; s_vse = '{0, 0};
        end else if (!cmd[0] || m_run == 0) begin
            m_run = int'(cmd[0]); m_bot = 0; m_pix = 0; m_line = 0;
            take_settings();
        end else begin
            total = (s_fm != 0) ? s_vae[1] : s_vae[0];
            if (m_pix == s_hae - 1) begin
                m_pix = 0;
                if (m_line == total - 1) begin
                    m_line = 0; m_bot = 0;
                    take_settings();
                end else begin
                    m_line++;
                    if (s_fm != 0 && m_line == s_vae[0]) m_bot = 1;
                end
            end else begin
                m_pix++;
            end
        end
    end

    // compare every output on every clock, away from the edge
    always @(posedge clk) begin
        longint pos, pb, pe, edgep;
        int e_hs, e_vs, e_de;
        #2;
        cyc++;
        e_hs = ((m_run != 0 && m_pix >= s_hab - s_hab + s_hsb && m_pix < s_hse) ? 1 : 0) ^ s_hsl;
        edgep = (m_bot != 0) ? longint'(s_hsb + s_sh) : 0;
        pos = longint'(m_line) * 65536 + m_pix;
        pb  = longint'(s_vsb[m_bot]) * 65536 + edgep;
        pe  = longint'(s_vse[m_bot]) * 65536 + edgep;
        e_vs = ((m_run != 0 && pos >= pb && pos < pe) ? 1 : 0) ^ s_vsl;
        e_de = (m_run != 0 && m_pix >= s_hab && m_pix < s_hae &&
                m_line >= s_vab[m_bot] && m_line < s_vae[m_bot]) ? 1 : 0;
        check(int'(pix_cnt) == m_pix, "R2 pix_cnt", pix_cnt, m_pix);
        check(int'(line_cnt) == m_line, "R2 line_cnt", line_cnt, m_line);
        check(int'(de) == e_de, "R3 de", de, e_de);
        check(int'(hsync) == e_hs, "R4 hsync", hsync, e_hs);
        check(int'(vsync) == e_vs, (s_fm != 0) ? "R7 vsync" : "R5 vsync", vsync, e_vs);
        check(int'(field) == m_bot, "R6 field", field, m_bot);
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 190000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_pos(input int l, input int p, input string tag);
        bit found = 0;
        for (int n = 0; n < 6000 && !found; n++) begin
            tick();
            if (int'(line_cnt) == l && int'(pix_cnt) == p) found = 1;
        end
        check(found, tag, found, 1);
    endtask

    initial begin
        int de44, de45, vsn, vsf, hsn, fn;
        repeat (3) tick();
        check(pix_cnt == '0 && line_cnt == '0 && !de && !hsync, "R1 reset state", pix_cnt, 0);
        rst_n = 1'b1;
        hsl = 1'b1; vsl = 1'b1;
        tick(); tick();
        check(hsync == 1'b1, "R1 idle hsync level", hsync, 1);
        check(vsync == 1'b1 && !de && pix_cnt == '0, "R1 idle vsync level", vsync, 1);

        // small progressive frame: 10 pixels x 5 lines
        hsl = 1'b0; vsl = 1'b0;
        hab = 3; hae = 10; hsb = 0; hse = 2;
        v0b = 1; v0e = 5; s0b = 0; s0e = 1;
        cmd = 2'b01;
        tick();
        check(pix_cnt == 0 && line_cnt == 0, "R8 start position", pix_cnt, 0);
        tick();
        check(pix_cnt == 1, "R8 second pixel", pix_cnt, 1);
        wait_pos(2, 0, "R9 reach line 2");
        hae = 14;
        wait_pos(2, 9, "R9 old line end");
        tick();
        check(pix_cnt == 0 && line_cnt == 3, "R9 old length held mid-frame", pix_cnt, 0);
        wait_pos(0, 0, "R9 frame wrap");
        wait_pos(0, 13, "R9 new length next frame");
        wait_pos(2, 5, "R8 reach disable point");
        cmd = 2'b00;
        tick();
        check(pix_cnt == 0 && line_cnt == 0 && !de, "R8 disable clears counters", pix_cnt, 0);
        check(hsync == 1'b0, "R1 disabled hsync inactive", hsync, 0);

        // small interlaced frame: 20 pixels x 12 lines
        hab = 4; hae = 20; hsb = 2; hse = 4; vsh = 10;
        v0b = 2; v0e = 6; v1b = 8; v1e = 12;
        s0b = 0; s0e = 1; s1b = 6; s1e = 7; vsl = 1'b1;
        tick();
        cmd = 2'b11;
        wait_pos(5, 19, "R6 reach end of field 0");
        check(field == 1'b0, "R6 field 0 before switch", field, 0);
        tick();
        check(field == 1'b1 && line_cnt == 6 && pix_cnt == 0, "R6 field switch", field, 1);
        wait_pos(6, 11, "R7 reach");
        check(vsync == 1'b1, "R7 field 1 vsync not yet", vsync, 1);
        tick();
        check(vsync == 1'b0, "R7 field 1 vsync asserts mid-line", vsync, 0);
        wait_pos(7, 4, "R6 reach");
        check(de == 1'b0, "R6 field 1 window closed", de, 0);
        wait_pos(7, 11, "R7 reach");
        check(vsync == 1'b0, "R7 field 1 vsync still on", vsync, 0);
        tick();
        check(vsync == 1'b1, "R7 field 1 vsync releases mid-line", vsync, 1);
        wait_pos(8, 4, "R6 reach");
        check(de == 1'b1, "R6 field 1 uses window 1", de, 1);
        wait_pos(11, 19, "R6 reach frame end");
        tick();
        check(line_cnt == 0 && field == 1'b0, "R6 interlaced frame length", line_cnt, 0);
        check(vsync == 1'b0, "R7 field 0 vsync at line start", vsync, 0);

        // progressive reference setting
        cmd = 2'b00;
        tick();
        hae = 858; hab = 138; hsb = 16; hse = 78; hsl = 1'b1;
        v0b = 45; v0e = 525; s0b = 9; s0e = 15; vsl = 1'b1;
        cmd = 2'b01;
        de44 = 0; de45 = 0; vsn = 0; vsf = -1; hsn = 0;
        for (int k = 0; k < 50 * 858; k++) begin
            tick();
            if (de && line_cnt == 44) de44++;
            if (de && line_cnt == 45) de45++;
            if (!hsync && line_cnt == 0) hsn++;
            if (!vsync && pix_cnt == 0) begin
                if (vsf < 0) vsf = int'(line_cnt);
                vsn++;
            end
        end
        check(de45 == 720, "R10 active pixels per line", de45, 720);
        check(de44 == 0, "R10 blank line before active", de44, 0);
        check(hsn == 62, "R10 hsync low width", hsn, 62);
        check(vsn == 6 && vsf == 9, "R10 vsync lines", vsf * 100 + vsn, 906);

        // interlaced reference setting, first lines of field 0
        cmd = 2'b00;
        tick();
        hae = 2200; hab = 280; hsb = 88; hse = 132; hsl = 1'b0; vsh = 1100;
        v0b = 22; v0e = 562; v1b = 585; v1e = 1125;
        s0b = 2; s0e = 7; s1b = 564; s1e = 569; vsl = 1'b0;
        cmd = 2'b11;
        de44 = 0; de45 = 0; vsn = 0; vsf = -1; hsn = 0; fn = 0;
        for (int k = 0; k < 30 * 2200; k++) begin
            tick();
            if (de && line_cnt == 21) de44++;
            if (de && line_cnt == 22) de45++;
            if (hsync && line_cnt == 0) hsn++;
            if (field) fn++;
            if (vsync && pix_cnt == 0) begin
                if (vsf < 0) vsf = int'(line_cnt);
                vsn++;
            end
        end
        check(de45 == 1920, "R11 active pixels per line", de45, 1920);
        check(de44 == 0, "R11 blank line before active", de44, 0);
        check(hsn == 44, "R11 hsync high width", hsn, 44);
        check(vsn == 5 && vsf == 2, "R11 vsync lines", vsf * 100 + vsn, 205);
        check(fn == 0, "R11 stays in field 0", fn, 0);

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule